// File: doc/BRIEF.md
# Serial Converter Host Sequencer

This block is the host side of a three-wire-plus-select serial link to a successive-approximation converter. A command is taken through a valid/ready port. The block sends eight command bits on the data-in line and reads the converter's reply on the data-out line during the same transfer. It generates chip select and the serial clock, and after a conversion it waits out the acquisition and conversion time and the end-of-conversion flag before it takes the next command. Each completed transfer is reported on a result port, together with its length and a flag that marks data which must not be trusted.

The transfer length is not fixed. The block follows every length, ordering, acquisition and mode command it sends, so it always clocks exactly as many bits as the converter expects. When chip select is never raised, this count is the only thing that keeps the two ends in step. Chip select can frame each transfer or stay low.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `cmd_ready_o` is high and `stat_o` is 0. The first transfers use 13 clocks with MSB-first reply order.
- R2: Each transfer produces exactly as many serial clock rising edges as the current word length, and `res_len_o` reports that count.
- R3: Op 2 selects the length from arg[1:0] (0→12, 1→13, 2→16, 3→17). The transfer that carries op 2 still uses the old length, and the new one applies from the next transfer on.
- R4: The serial clock period is SCLK_DIV system clocks and the clock idles low. Data-in changes only while the clock is low, and data-out is sampled on the rising edge. The first 8 data-in bits are {op[3:0], arg[3:0]} MSB first, and the remaining bits are 0, so a conversion's channel address travels in the transfer that starts it.
- R5: With `cs_framed_i` high, chip select is high whenever no transfer is running. With it low, chip select stays low after the first transfer.
- R6: Op 3 arg[0] sets the reply order for later transfers (1 = MSB first, 0 = LSB first). `res_data_o` holds the reply right-aligned, with upper bits zero.
- R7: Op 4 arg[1:0] sets acquisition to 6, 10, 18 or 34 converter clocks. After an op 1 (convert) transfer, `cmd_ready_o` rises exactly max((acq+CONV_PERIODS)·CCLK_DIV, CS_GAP)+1 cycles after `res_valid_o`, and never while `eoc_i` is low. After any other transfer it rises CS_GAP+1 cycles after `res_valid_o`.
- R8: The reply of a transfer carrying op 5 or op 6 (calibration, zeroing) is reported with `res_good_o` low.
- R9: After op 9 (enter test mode), and after op 10 (leave test mode) until op 8, op 2 and op 4 have each been sent again, op 1 is refused: `cmd_reject_o` pulses and no transfer starts.
- R10: If `pd_i` is high while a conversion runs, the next transfer's `res_good_o` is low. The transfer after that is good again.
- R11: The transfer that follows an op 7 transfer loads `stat_o` from reply bits 2:0 (bit 0 power-up busy, bit 1 power-down busy, bit 2 calibration busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_framed_i | input | 1 | 1: chip select frames each transfer; 0: chip select stays low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command acknowledge; a command is taken when both are high |
| cmd_op_i | input | 4 | Command opcode |
| cmd_arg_i | input | 4 | Command argument (channel, selector or flag) |
| cmd_reject_o | output | 1 | One-cycle pulse for a refused convert |
| res_valid_o | output | 1 | One-cycle pulse when a transfer has ended |
| res_data_o | output | 17 | Captured reply, right-aligned |
| res_len_o | output | 5 | Clock count of that transfer |
| res_good_o | output | 1 | Reply is usable |
| stat_o | output | 3 | Last status readback bits |
| eoc_i | input | 1 | End of conversion from the converter |
| pd_i | input | 1 | Hardware power-down line, observed |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_sclk_o | output | 1 | Serial clock |
| adc_di_o | output | 1 | Serial data to converter |
| adc_do_i | input | 1 | Serial data from converter |

## Verification
The bench builds the block with SCLK_DIV=4, CCLK_DIV=2, CONV_PERIODS=4 and CS_GAP=2. With these values every length and order pair, every acquisition selection and every post-conversion wait can be swept in both chip-select modes within a short run, and each wait is checked to the exact cycle. A behavioural converter model in the bench follows its own copy of the length and order state. A drift in the clock count or in the ordering shows up as a wrong clock count, wrong data-in bits or a bit-reversed reply.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

   localparam int CMD_BITS  = 8;
   localparam int WORD_MAX  = 17;
   localparam int LEN_W     = 5;

   typedef enum logic [3:0] {
      OP_READ      = 4'd0,
      OP_CONVERT   = 4'd1,
      OP_SET_LEN   = 4'd2,
      OP_SET_ORDER = 4'd3,
      OP_SET_ACQ   = 4'd4,
      OP_AUTOCAL   = 4'd5,
      OP_AUTOZERO  = 4'd6,
      OP_STATUS    = 4'd7,
      OP_POWER_UP  = 4'd8,
      OP_TEST_ON   = 4'd9,
      OP_TEST_OFF  = 4'd10
   } op_e;

   // length selector -> clock count of a transfer
   function automatic logic [LEN_W-1:0] len_of(input logic [1:0] sel);
      case (sel)
         2'd0:    return 5'd12;
         2'd1:    return 5'd13;
         2'd2:    return 5'd16;
         default: return 5'd17;
      endcase
   endfunction

   // acquisition selector -> converter clock periods
   function automatic int unsigned acq_of(input logic [1:0] sel);
      case (sel)
         2'd0:    return 6;
         2'd1:    return 10;
         2'd2:    return 18;
         default: return 34;
      endcase
   endfunction

endpackage

// File: rtl/ahs_cfg_track.sv
module ahs_cfg_track
   import adc_host_pkg::*;
#(
   parameter logic [1:0] RST_ACQ_SEL = 2'd1
)(
   input  logic       clk,
   input  logic       rst,
   input  logic       upd,
   input  op_e        op,
   input  logic [1:0] arg,
   output logic [1:0] len_sel,
   output logic [1:0] acq_sel,
   output logic       msb_first,
   output logic       conv_blocked
);

   localparam logic [1:0] RST_LEN_SEL = 2'd1;   // 13 clocks after reset
   localparam int         NEED_W      = 3;       // power-up, length/sign, acquisition

   logic [NEED_W-1:0] need;
   logic              test_on;

   always_ff @(posedge clk) begin
      if (rst) begin
         len_sel   <= RST_LEN_SEL;
         acq_sel   <= RST_ACQ_SEL;
         msb_first <= 1'b1;
         need      <= '0;
         test_on   <= 1'b0;
      end else if (upd) begin
         case (op)
            OP_SET_LEN: begin
               len_sel <= arg;
               need[1] <= 1'b0;
            end
            OP_SET_ORDER: msb_first <= arg[0];
            OP_SET_ACQ: begin
               acq_sel <= arg;
               need[2] <= 1'b0;
            end
            OP_POWER_UP: need[0] <= 1'b0;
            OP_TEST_ON:  test_on <= 1'b1;
            OP_TEST_OFF: begin
               test_on <= 1'b0;
               need    <= '1;
            end
            default: ;
         endcase
      end
   end

   assign conv_blocked = test_on || (need != '0);

endmodule

// File: rtl/ahs_serial_engine.sv
module ahs_serial_engine
   import adc_host_pkg::*;
#(
   parameter int SCLK_DIV = 4
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                framed,
   input  logic                start,
   input  logic [CMD_BITS-1:0] cmd_bits,
   input  logic [LEN_W-1:0]    len,
   input  logic                msb_first,
   input  logic                do_i,
   output logic                busy,
   output logic                finish,
   output logic [LEN_W-1:0]    cur_len,
   output logic [WORD_MAX-1:0] cap,
   output logic                cs_n,
   output logic                sclk,
   output logic                di
);

   localparam int HALF = SCLK_DIV / 2;
   localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;

   logic                tick;
   logic                phase_hi;
   logic [LEN_W-1:0]    bitn;
   logic [CMD_BITS-1:0] cmd_q;
   logic                msb_q;
   logic                last;
   logic [LEN_W-1:0]    pos;
   logic [LEN_W-1:0]    nb;
   logic                nxt_di;

   // half-period timing: a variant per divisor
   if (HALF == 1) begin : g_tick_every
      assign tick = 1'b1;
   end else begin : g_tick_cnt
      logic [HCW-1:0] hcnt;
      always_ff @(posedge clk) begin
         if (rst || !busy || tick) hcnt <= '0;
         else                      hcnt <= hcnt + 1'b1;
      end
      assign tick = (hcnt == HCW'(HALF - 1));
   end

   assign last   = (bitn == cur_len - 5'd1);
   assign finish = busy && phase_hi && tick && last;
   assign pos    = msb_q ? (cur_len - 5'd1 - bitn) : bitn;
   assign nb     = bitn + 5'd1;
   assign nxt_di = (nb < 5'(CMD_BITS)) ? cmd_q[3'd7 - nb[2:0]] : 1'b0;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy     <= 1'b0;
         cs_n     <= 1'b1;
         sclk     <= 1'b0;
         di       <= 1'b0;
         phase_hi <= 1'b0;
         bitn     <= '0;
         cap      <= '0;
         cur_len  <= 5'd13;
         msb_q    <= 1'b1;
         cmd_q    <= '0;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            cs_n     <= 1'b0;
            sclk     <= 1'b0;
            di       <= cmd_bits[CMD_BITS-1];
            cmd_q    <= cmd_bits;
            cur_len  <= len;
            msb_q    <= msb_first;
            bitn     <= '0;
            phase_hi <= 1'b0;
            cap      <= '0;
         end else if (framed) begin
            cs_n <= 1'b1;
         end
      end else if (tick) begin
         if (!phase_hi) begin
            sclk     <= 1'b1;
            phase_hi <= 1'b1;
            cap[pos] <= do_i;
         end else begin
            sclk     <= 1'b0;
            phase_hi <= 1'b0;
            if (last) begin
               busy <= 1'b0;
               cs_n <= framed;
               di   <= 1'b0;
            end else begin
               bitn <= nb;
               di   <= nxt_di;
            end
         end
      end
   end

endmodule

// File: rtl/ahs_post_timer.sv
module ahs_post_timer
   import adc_host_pkg::*;
#(
   parameter int CCLK_DIV     = 2,
   parameter int CONV_PERIODS = 44,
   parameter int CS_GAP       = 2
)(
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic       is_conv,
   input  logic [1:0] acq_sel,
   input  logic       eoc_i,
   output logic       busy,
   output logic       conv_phase
);

   localparam int MAX_WAIT = (34 + CONV_PERIODS) * CCLK_DIV;
   localparam int TOP      = (MAX_WAIT > CS_GAP) ? MAX_WAIT : CS_GAP;
   localparam int CW       = $clog2(TOP + 1);

   logic [CW-1:0] cnt;
   logic          conv_q;

   function automatic logic [CW-1:0] wait_of(input logic [1:0] sel);
      int unsigned w;
      w = (acq_of(sel) + CONV_PERIODS) * CCLK_DIV;
      return (w > CS_GAP) ? CW'(w) : CW'(CS_GAP);
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         conv_q <= 1'b0;
         cnt    <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         conv_q <= is_conv;
         cnt    <= is_conv ? wait_of(acq_sel) : CW'(CS_GAP);
      end else if (busy) begin
         if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else if (!conv_q || eoc_i) begin
            busy   <= 1'b0;
            conv_q <= 1'b0;
         end
      end
   end

   assign conv_phase = busy && conv_q;

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
   import adc_host_pkg::*;
#(
   parameter int         SCLK_DIV     = 4,
   parameter int         CCLK_DIV     = 2,
   parameter int         CONV_PERIODS = 44,
   parameter int         CS_GAP       = 2,
   parameter logic [1:0] RST_ACQ_SEL  = 2'd1
)(
   input  logic        clk,
   input  logic        rst,
   input  logic        cs_framed_i,
   input  logic        cmd_valid_i,
   output logic        cmd_ready_o,
   input  logic [3:0]  cmd_op_i,
   input  logic [3:0]  cmd_arg_i,
   output logic        cmd_reject_o,
   output logic        res_valid_o,
   output logic [16:0] res_data_o,
   output logic [4:0]  res_len_o,
   output logic        res_good_o,
   output logic [2:0]  stat_o,
   input  logic        eoc_i,
   input  logic        pd_i,
   output logic        adc_cs_n_o,
   output logic        adc_sclk_o,
   output logic        adc_di_o,
   input  logic        adc_do_i
);

   // elaboration-time parameter checks
   if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin : g_bad_sclk_div
      $error("SCLK_DIV must be even and at least 2");
   end
   if (CCLK_DIV < 1) begin : g_bad_cclk_div
      $error("CCLK_DIV must be at least 1");
   end
   if (CONV_PERIODS < 1) begin : g_bad_conv
      $error("CONV_PERIODS must be at least 1");
   end
   if (CS_GAP < 1) begin : g_bad_gap
      $error("CS_GAP must be at least 1");
   end

   logic                eng_busy, eng_finish;
   logic                tmr_busy, conv_phase;
   logic [LEN_W-1:0]    cur_len;
   logic [WORD_MAX-1:0] cap;
   logic [1:0]          len_sel, acq_sel;
   logic                msb_first, conv_blocked;
   op_e                 in_op, op_q;
   logic [1:0]          arg_q;
   logic                take, refuse, start;
   logic                corrupt, status_due;

   assign cmd_ready_o = !eng_busy && !tmr_busy;
   assign in_op       = op_e'(cmd_op_i);
   assign take        = cmd_valid_i && cmd_ready_o;
   assign refuse      = take && (in_op == OP_CONVERT) && conv_blocked;
   assign start       = take && !refuse;

   ahs_cfg_track #(
      .RST_ACQ_SEL (RST_ACQ_SEL)
   ) u_cfg (
      .clk          (clk),
      .rst          (rst),
      .upd          (eng_finish),
      .op           (op_q),
      .arg          (arg_q),
      .len_sel      (len_sel),
      .acq_sel      (acq_sel),
      .msb_first    (msb_first),
      .conv_blocked (conv_blocked)
   );

   ahs_serial_engine #(
      .SCLK_DIV (SCLK_DIV)
   ) u_eng (
      .clk       (clk),
      .rst       (rst),
      .framed    (cs_framed_i),
      .start     (start),
      .cmd_bits  ({cmd_op_i, cmd_arg_i}),
      .len       (len_of(len_sel)),
      .msb_first (msb_first),
      .do_i      (adc_do_i),
      .busy      (eng_busy),
      .finish    (eng_finish),
      .cur_len   (cur_len),
      .cap       (cap),
      .cs_n      (adc_cs_n_o),
      .sclk      (adc_sclk_o),
      .di        (adc_di_o)
   );

   ahs_post_timer #(
      .CCLK_DIV     (CCLK_DIV),
      .CONV_PERIODS (CONV_PERIODS),
      .CS_GAP       (CS_GAP)
   ) u_tmr (
      .clk        (clk),
      .rst        (rst),
      .load       (eng_finish),
      .is_conv    (op_q == OP_CONVERT),
      .acq_sel    (acq_sel),
      .eoc_i      (eoc_i),
      .busy       (tmr_busy),
      .conv_phase (conv_phase)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q         <= OP_READ;
         arg_q        <= '0;
         cmd_reject_o <= 1'b0;
         res_valid_o  <= 1'b0;
         res_data_o   <= '0;
         res_len_o    <= '0;
         res_good_o   <= 1'b0;
         stat_o       <= '0;
         corrupt      <= 1'b0;
         status_due   <= 1'b0;
      end else begin
         cmd_reject_o <= refuse;
         res_valid_o  <= eng_finish;
         if (start) begin
            op_q  <= in_op;
            arg_q <= cmd_arg_i[1:0];
         end
         if (eng_finish) begin
            res_data_o <= cap;
            res_len_o  <= cur_len;
            res_good_o <= !corrupt && (op_q != OP_AUTOCAL) && (op_q != OP_AUTOZERO);
            corrupt    <= 1'b0;
            status_due <= (op_q == OP_STATUS);
            if (status_due) stat_o <= cap[2:0];
         end else if (conv_phase && pd_i) begin
            corrupt <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ahs_host_checker.sv
module ahs_host_checker
   import adc_host_pkg::*;
#(
   parameter int CCLK_DIV     = 2,
   parameter int CONV_PERIODS = 44
)(
   input logic       clk,
   input logic       rst,
   input logic       cs_framed_i,
   input logic       cmd_ready_o,
   input logic       cmd_reject_o,
   input logic       res_valid_o,
   input logic [4:0] res_len_o,
   input logic       res_good_o,
   input logic       adc_cs_n_o,
   input logic       adc_sclk_o,
   input logic       adc_di_o,
   input logic [3:0] op_q,
   input logic [1:0] acq_sel
);

   logic [15:0] since;
   logic        after_conv;
   int          min_wait;

   always_ff @(posedge clk) begin
      if (rst) begin
         since      <= '0;
         after_conv <= 1'b0;
      end else begin
         if (res_valid_o) begin
            since      <= 16'd1;
            after_conv <= (op_q == 4'd1);
         end else if (since != 16'hFFFF) begin
            since <= since + 16'd1;
         end
      end
   end

   assign min_wait = int'((acq_of(acq_sel) + CONV_PERIODS) * CCLK_DIV);

   // R4: serial clock idles low between transfers
   a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
      cmd_ready_o |-> !adc_sclk_o);

   // R4: data-in holds while the clock is high
   a_r4_di_steady_high: assert property (@(posedge clk) disable iff (rst)
      adc_sclk_o && $past(adc_sclk_o) |-> $stable(adc_di_o));

   // R5: framed mode keeps select high while idle
   a_r5_cs_high_framed_idle: assert property (@(posedge clk) disable iff (rst)
      cs_framed_i && $past(cs_framed_i) && cmd_ready_o && $past(cmd_ready_o) |-> adc_cs_n_o);

   // R2: reported length is one of the legal counts
   a_r2_len_legal: assert property (@(posedge clk) disable iff (rst)
      res_valid_o |-> (res_len_o == 5'd12 || res_len_o == 5'd13 ||
                       res_len_o == 5'd16 || res_len_o == 5'd17));

   // R8: calibration and zeroing replies are flagged unusable
   a_r8_cal_data_flagged: assert property (@(posedge clk) disable iff (rst)
      res_valid_o && (op_q == 4'd5 || op_q == 4'd6) |-> !res_good_o);

   // R9: a refused convert leaves the link idle
   a_r9_reject_stays_idle: assert property (@(posedge clk) disable iff (rst)
      cmd_reject_o |-> cmd_ready_o && !adc_sclk_o);

   // R7: no new command before acquisition plus conversion time
   a_r7_wait_honoured: assert property (@(posedge clk) disable iff (rst)
      after_conv && cmd_ready_o && !res_valid_o |-> int'(since) > min_wait);

endmodule

bind adc_serial_host ahs_host_checker #(
   .CCLK_DIV     (CCLK_DIV),
   .CONV_PERIODS (CONV_PERIODS)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .cs_framed_i  (cs_framed_i),
   .cmd_ready_o  (cmd_ready_o),
   .cmd_reject_o (cmd_reject_o),
   .res_valid_o  (res_valid_o),
   .res_len_o    (res_len_o),
   .res_good_o   (res_good_o),
   .adc_cs_n_o   (adc_cs_n_o),
   .adc_sclk_o   (adc_sclk_o),
   .adc_di_o     (adc_di_o),
   .op_q         (op_q),
   .acq_sel      (acq_sel)
);

// File: tb/tb_adc_serial_host.sv
module tb_adc_serial_host;

   localparam int CLK_PERIOD = 10;
   localparam int P_SCLK     = 4;
   localparam int P_CCLK     = 2;
   localparam int P_CONV     = 4;
   localparam int P_GAP      = 2;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs_framed = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic [3:0]  cmd_arg = '0;
   logic        eoc = 1'b1;
   logic        pd = 1'b0;
   logic        cmd_ready, cmd_reject, res_valid, res_good;
   logic [16:0] res_data;
   logic [4:0]  res_len;
   logic [2:0]  stat;
   logic        cs_n, sclk, di_line;
   logic        do_line;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   // converter model state (bench-side expectation)
   int          rise_total = 0;
   int          xfer_base  = 0;
   logic [31:0] di_cap     = '0;
   logic [16:0] tx_word    = '0;
   int          tx_len     = 13;
   bit          tx_msb     = 1'b1;
   int          e_len = 13;
   bit          e_msb = 1'b1;
   int          e_acq = 10;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_serial_host #(
      .SCLK_DIV     (P_SCLK),
      .CCLK_DIV     (P_CCLK),
      .CONV_PERIODS (P_CONV),
      .CS_GAP       (P_GAP)
   ) dut (
      .clk          (clk),
      .rst          (rst),
      .cs_framed_i  (cs_framed),
      .cmd_valid_i  (cmd_valid),
      .cmd_ready_o  (cmd_ready),
      .cmd_op_i     (cmd_op),
      .cmd_arg_i    (cmd_arg),
      .cmd_reject_o (cmd_reject),
      .res_valid_o  (res_valid),
      .res_data_o   (res_data),
      .res_len_o    (res_len),
      .res_good_o   (res_good),
      .stat_o       (stat),
      .eoc_i        (eoc),
      .pd_i         (pd),
      .adc_cs_n_o   (cs_n),
      .adc_sclk_o   (sclk),
      .adc_di_o     (di_line),
      .adc_do_i     (do_line)
   );

   always @(posedge sclk) begin
      di_cap     <= {di_cap[30:0], di_line};
      rise_total <= rise_total + 1;
   end

   always_comb begin
      int k;
      k = rise_total - xfer_base;
      if (k < tx_len) do_line = tx_msb ? tx_word[tx_len-1-k] : tx_word[k];
      else            do_line = 1'b0;
   end

   function automatic int blen(input int sel);
      case (sel)
         0: return 12;
         1: return 13;
         2: return 16;
         default: return 17;
      endcase
   endfunction

   function automatic int bacq(input int sel);
      case (sel)
         0: return 6;
         1: return 10;
         2: return 18;
         default: return 34;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ready();
      while (!cmd_ready) @(negedge clk);
   endtask

   // one transfer; checks count, DI bits, data, flag, then the gap to ready
   task automatic xfer(input int op, input int arg, input logic [16:0] word,
                       input bit exp_good, input bit chk_delay);
      int          len_now;
      logic [31:0] mask;
      logic [31:0] exp_di;
      int          cnt;
      int          exp_gap;
      len_now = e_len;
      wait_ready();
      tx_word   = word;
      tx_len    = len_now;
      tx_msb    = e_msb;
      xfer_base = rise_total;
      cmd_op    = 4'(op);
      cmd_arg   = 4'(arg);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!res_valid) @(negedge clk);
      mask   = (32'd1 << len_now) - 32'd1;
      exp_di = {24'd0, 4'(op), 4'(arg)} << (len_now - 8);
      chk(rise_total - xfer_base == len_now, "R2 clock count", rise_total - xfer_base, len_now);
      chk(int'(res_len) == len_now, "R2 res_len", res_len, len_now);
      chk((di_cap & mask) == exp_di, "R4 DI bits", di_cap & mask, exp_di);
      chk({15'd0, res_data} == ({15'd0, word} & mask), "R6 reply data", res_data, {15'd0, word} & mask);
      chk(res_good == exp_good, "R8/R10 res_good", res_good, exp_good);
      if (op == 2) e_len = blen(arg & 3);
      if (op == 3) e_msb = arg[0];
      if (op == 4) e_acq = bacq(arg & 3);
      if (chk_delay) begin
         cnt = 0;
         while (!cmd_ready) begin
            @(negedge clk);
            cnt++;
         end
         if (op == 1) begin
            exp_gap = (e_acq + P_CONV) * P_CCLK;
            if (exp_gap < P_GAP) exp_gap = P_GAP;
         end else begin
            exp_gap = P_GAP;
         end
         chk(cnt == exp_gap + 1, "R7 ready delay", cnt, exp_gap + 1);
         chk(cs_n == cs_framed, "R5 chip select idle", cs_n, cs_framed);
      end
   endtask

   task automatic try_refused();
      int base;
      int seen;
      wait_ready();
      base      = rise_total;
      cmd_op    = 4'd1;
      cmd_arg   = 4'd0;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_reject == 1'b1, "R9 reject pulse", cmd_reject, 1);
      seen = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!cmd_ready) seen++;
      end
      chk(rise_total == base && seen == 0, "R9 no transfer", rise_total - base, 0);
   endtask

   // watchdog
   initial begin
      while (cycles < WATCHDOG) begin
         @(negedge clk);
         cycles++;
      end
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hits;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(cs_n == 1'b1, "R1 cs high", cs_n, 1);
      chk(sclk == 1'b0, "R1 sclk low", sclk, 0);
      chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
      chk(stat == 3'd0, "R1 stat", stat, 0);
      rst = 1'b0;
      @(negedge clk);

      // R1: first transfer is 13 clocks, MSB first
      xfer(0, 0, 17'h1A5B3, 1'b1, 1'b1);

      // R3, R6, R5: sweep every length and order in both select modes
      for (int fm = 1; fm >= 0; fm--) begin
         cs_framed = fm[0];
         for (int ls = 0; ls < 4; ls++) begin
            for (int o = 0; o < 2; o++) begin
               xfer(2, ls, 17'h15A5A ^ 17'(ls * 7), 1'b1, 1'b1);
               xfer(3, o, 17'h0F0F1, 1'b1, 1'b1);
               xfer(1, ls * 2 + o, 17'h1C3E7, 1'b1, 1'b1);
               xfer(0, 0, 17'h10001 | 17'(o << 4) | 17'(ls << 9), 1'b1, 1'b1);
            end
         end
      end
      cs_framed = 1'b1;
      xfer(2, 1, 17'h0, 1'b1, 1'b1);
      xfer(3, 1, 17'h0, 1'b1, 1'b1);

      // R7: each acquisition time
      for (int a = 0; a < 4; a++) begin
         xfer(4, a, 17'h00ABC, 1'b1, 1'b1);
         xfer(1, a + 4, 17'h01234, 1'b1, 1'b1);
      end

      // R7: end-of-conversion held low stretches the wait
      xfer(1, 5, 17'h00FFF, 1'b1, 1'b0);
      eoc = 1'b0;
      hits = 0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (cmd_ready) hits++;
      end
      chk(hits == 0, "R7 waits for eoc", hits, 0);
      eoc = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R7 ready after eoc", cmd_ready, 1);

      // R8: calibration and zeroing replies flagged
      xfer(5, 0, 17'h00777, 1'b0, 1'b1);
      xfer(6, 0, 17'h00555, 1'b0, 1'b1);
      xfer(0, 0, 17'h00333, 1'b1, 1'b1);

      // R10: power-down during conversion spoils the next reply
      xfer(1, 2, 17'h00111, 1'b1, 1'b0);
      pd = 1'b1;
      repeat (3) @(negedge clk);
      pd = 1'b0;
      xfer(0, 0, 17'h00222, 1'b0, 1'b1);
      xfer(0, 0, 17'h00444, 1'b1, 1'b1);

      // R11: status readback
      xfer(7, 0, 17'h00000, 1'b1, 1'b1);
      xfer(0, 0, 17'h00FF5, 1'b1, 1'b1);
      chk(stat == 3'b101, "R11 status bits", stat, 5);
      xfer(0, 0, 17'h00002, 1'b1, 1'b1);
      chk(stat == 3'b101, "R11 status only after op 7", stat, 5);

      // R9: test mode gating of conversions
      xfer(9, 0, 17'h0, 1'b1, 1'b1);
      try_refused();
      xfer(10, 0, 17'h0, 1'b1, 1'b1);
      try_refused();
      xfer(8, 0, 17'h0, 1'b1, 1'b1);
      xfer(2, 2, 17'h0, 1'b1, 1'b1);
      try_refused();
      xfer(4, 0, 17'h0, 1'b1, 1'b1);
      xfer(1, 1, 17'h0BEEF, 1'b1, 1'b1);
      chk(cmd_reject == 1'b0, "R9 convert accepted", cmd_reject, 0);
      xfer(0, 0, 17'h1FFFF, 1'b1, 1'b1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule